// File: doc/BRIEF.md
# Flash Byte-Program Controller

This block sits between an 8-bit CPU I/O bus and a flash array and turns a single register write into a timed byte-program cycle. Software first loads the column, page and row registers that select the target byte, then sets a clock divider and writes the data byte. The data write starts the cycle. A wait line stalls the CPU until the program pulse finishes. The pulse lasts a fixed number of divided ticks, so with a 1 µs tick it falls inside the 66–85 µs window the flash cells need.

The controller also guards the array. Each row of 128 bytes has a budget of 16 ms of total program time between erases. No byte may be programmed more than twice between erases. The controller refuses any write that would break either rule, or that arrives while the divider is zero. A refused write records a sticky, write-one-to-clear error bit and drives no pulse to the array. A row erase command clears the row's time total and the program counts of all its bytes.

Top module: `flash_byte_prog`

## Requirements
- R1: Register codes on `io_addr` are 0 column, 1 page, 2 row, 3 data, 4 divider, 5 control, 6 status. Reads return the stored value zero-extended (control reads 0). The target byte is {page,row,column}. After reset every register reads 0.
- R2: A write to the data register while idle raises `cpu_wait` in the cycle after the write edge.
- R3: An accepted write holds `fl_prog` and `cpu_wait` high for exactly PULSE_TICKS×divider clock cycles. During the pulse, `fl_addr`={page,row,column} and `fl_data`=the written byte stay stable.
- R4: The divider is an 8-bit down-counter reloaded from the divider register, giving one tick every divider clock cycles. The default is 75 ticks per pulse.
- R5: A program attempt to a byte that has already been programmed twice since its row's last erase is refused and sets status bit 1. This check takes precedence over the budget check.
- R6: A program that would take a row's accumulated time above BUDGET_TICKS (default 16000) is refused and sets status bit 2. Each accepted program adds PULSE_TICKS.
- R7: A data write while the divider register is 0 is refused and sets status bit 3. This check takes precedence over all others, and each refusal sets exactly one bit.
- R8: After a refused write, `cpu_wait` is high for exactly one cycle, and `fl_prog` stays low.
- R9: Writing the control register with bit 0 set clears the selected row's time total and all its byte counts. `fl_erase` then pulses for one cycle, with `fl_addr`={page,row,0}.
- R10: Status bit 0 mirrors `cpu_wait`. Status bits 3:1 are sticky and are cleared by writing 1 to them.
- R11: Register writes that arrive while `cpu_wait` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 3 | Register select |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the selected register |
| cpu_wait | output | 1 | CPU stall |
| fl_prog | output | 1 | Program pulse to the array |
| fl_erase | output | 1 | One-cycle row erase strobe |
| fl_addr | output | COL_W+PAGE_W+ROW_W | Array byte address |
| fl_data | output | 8 | Byte being programmed |

## Verification
A write is sampled at one edge, and every result it causes becomes visible after that edge. The wait line and the program pulse rise right after it. The erase strobe is high for the one cycle that follows it. A refusal lifts the wait line for exactly one cycle. An accepted pulse ends after PULSE_TICKS×divider cycles. The bench advances a behavioural model at each rising edge and compares it with the outputs at the falling edge. Status and register reads are compared one nanosecond after the address settles, and pulse lengths are counted in falling edges.

// File: rtl/flash_byte_prog.sv
module flash_byte_prog #(
  parameter int COL_W        = 7,
  parameter int PAGE_W       = 1,
  parameter int ROW_W        = 1,
  parameter int PULSE_TICKS  = 75,
  parameter int BUDGET_TICKS = 16000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic [2:0]                    io_addr,
  input  logic [7:0]                    io_wdata,
  output logic [7:0]                    io_rdata,
  output logic                          cpu_wait,
  output logic                          fl_prog,
  output logic                          fl_erase,
  output logic [COL_W+PAGE_W+ROW_W-1:0] fl_addr,
  output logic [7:0]                    fl_data
);
  localparam int SEL_W  = PAGE_W + ROW_W;
  localparam int ADDR_W = SEL_W + COL_W;
  localparam int NROWS  = 1 << SEL_W;
  localparam int NCOLS  = 1 << COL_W;
  localparam int NBYTES = NROWS * NCOLS;
  localparam int ACC_W  = $clog2(BUDGET_TICKS + 1);
  localparam int TCK_W  = $clog2(PULSE_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_REJ} st_t;
  st_t st;

  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;
  logic [ROW_W-1:0]  row_q;
  logic [7:0]        data_q, div_q, dcnt;
  logic [2:0]        err_q;
  logic [TCK_W-1:0]  ticks;
  logic [1:0]        pcnt [NBYTES];
  logic [ACC_W-1:0]  acc  [NROWS];

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] tgt;
  logic [ACC_W:0]    acc_next;
  logic wr_ok, start, bad_div, bad_cnt, bad_bud, accept, reject, erase_cmd, tick, last;

  assign sel       = {page_q, row_q};
  assign tgt       = {sel, col_q};
  assign wr_ok     = io_wr && (st == S_IDLE);
  assign start     = wr_ok && (io_addr == 3'd3);
  assign erase_cmd = wr_ok && (io_addr == 3'd5) && io_wdata[0];
  assign acc_next  = {1'b0, acc[sel]} + (ACC_W+1)'(PULSE_TICKS);
  assign bad_div   = (div_q == 8'd0);
  assign bad_cnt   = (pcnt[tgt] == 2'd2);
  assign bad_bud   = acc_next > (ACC_W+1)'(BUDGET_TICKS);
  assign accept    = start && !bad_div && !bad_cnt && !bad_bud;
  assign reject    = start && !accept;
  assign tick      = (st == S_PROG) && (dcnt == 8'd0);
  assign last      = tick && (ticks == TCK_W'(PULSE_TICKS - 1));
  assign cpu_wait  = (st != S_IDLE);
  assign fl_prog   = (st == S_PROG);

  always_comb begin
    case (io_addr)
      3'd0:    io_rdata = 8'(col_q);
      3'd1:    io_rdata = 8'(page_q);
      3'd2:    io_rdata = 8'(row_q);
      3'd3:    io_rdata = data_q;
      3'd4:    io_rdata = div_q;
      3'd6:    io_rdata = {4'd0, err_q, cpu_wait};
      default: io_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0; page_q <= '0; row_q <= '0;
      data_q <= '0; div_q <= '0; err_q <= '0;
    end else begin
      if (wr_ok) begin
        case (io_addr)
          3'd0:    col_q  <= io_wdata[COL_W-1:0];
          3'd1:    page_q <= io_wdata[PAGE_W-1:0];
          3'd2:    row_q  <= io_wdata[ROW_W-1:0];
          3'd3:    data_q <= io_wdata;
          3'd4:    div_q  <= io_wdata;
          3'd6:    err_q  <= err_q & ~io_wdata[3:1];
          default: ;
        endcase
      end
      if (reject) begin
        if (bad_div)      err_q[2] <= 1'b1;
        else if (bad_cnt) err_q[0] <= 1'b1;
        else              err_q[1] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; ticks <= '0;
      fl_addr <= '0; fl_data <= '0; fl_erase <= 1'b0;
    end else begin
      fl_erase <= erase_cmd;
      if (erase_cmd) fl_addr <= {sel, {COL_W{1'b0}}};
      case (st)
        S_IDLE: begin
          if (accept) begin
            st <= S_PROG; dcnt <= div_q - 8'd1; ticks <= '0;
            fl_addr <= tgt; fl_data <= io_wdata;
          end else if (reject) st <= S_REJ;
        end
        S_PROG: begin
          if (tick) begin
            dcnt  <= div_q - 8'd1;
            ticks <= ticks + 1'b1;
            if (last) st <= S_IDLE;
          end else dcnt <= dcnt - 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) pcnt[i] <= '0;
      for (int r = 0; r < NROWS; r++)  acc[r]  <= '0;
    end else if (accept) begin
      pcnt[tgt] <= pcnt[tgt] + 2'd1;
      acc[sel]  <= acc_next[ACC_W-1:0];
    end else if (erase_cmd) begin
      for (int c = 0; c < NCOLS; c++) pcnt[{sel, COL_W'(c)}] <= '0;
      acc[sel] <= '0;
    end
  end

  logic [31:0] plen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        plen <= '0;
    else if (!fl_prog) plen <= '0;
    else               plen <= plen + 32'd1;

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_prog) |-> plen == 32'(PULSE_TICKS) * 32'(div_q));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_prog && $past(fl_prog) |-> $stable(fl_addr) && $stable(fl_data));
  // R2
  start_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cpu_wait);
  // R8
  reject_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !fl_prog ##1 !cpu_wait);
  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && div_q == 8'd0 |=> !fl_prog);
  // R6
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc[sel] <= ACC_W'(BUDGET_TICKS));
endmodule

// File: tb/flash_byte_prog_test.sv
module flash_byte_prog_test;
  localparam int P = 75;
  localparam int B = 16000;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0;
  logic [2:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata, fl_data;
  logic cpu_wait, fl_prog, fl_erase;
  logic [8:0] fl_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  flash_byte_prog uut (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_wait(cpu_wait), .fl_prog(fl_prog),
    .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_data(fl_data));

  always #4 clk = ~clk;

  int m_col, m_page, m_row, m_data, m_div, m_err, m_rem, m_faddr, m_fdata;
  bit m_prog, m_erase;
  int m_cnt [512];
  int m_acc [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_col = 0; m_page = 0; m_row = 0; m_data = 0; m_div = 0; m_err = 0;
      m_rem = 0; m_prog = 0; m_erase = 0; m_faddr = 0; m_fdata = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      foreach (m_acc[i]) m_acc[i] = 0;
    end else begin
      m_erase = 0;
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) m_prog = 0;
      end else if (io_wr) begin
        int s, t;
        s = m_page * 2 + m_row;
        t = s * 128 + m_col;
        case (io_addr)
          0: m_col = io_wdata & 8'h7f;
          1: m_page = io_wdata & 1;
          2: m_row = io_wdata & 1;
          3: begin
            m_data = io_wdata;
            if (m_div == 0) begin m_err |= 8; m_rem = 1; end
            else if (m_cnt[t] >= 2) begin m_err |= 2; m_rem = 1; end
            else if (m_acc[s] + P > B) begin m_err |= 4; m_rem = 1; end
            else begin
              m_cnt[t]++; m_acc[s] += P; m_rem = P * m_div; m_prog = 1;
              m_faddr = t; m_fdata = io_wdata;
            end
          end
          4: m_div = io_wdata;
          5: if (io_wdata[0]) begin
               for (int c = 0; c < 128; c++) m_cnt[s*128+c] = 0;
               m_acc[s] = 0; m_erase = 1; m_faddr = s * 128;
             end
          6: m_err &= ~(int'(io_wdata) & 14);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 R3 R9: outputs compared every cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R8 cpu_wait", int'(cpu_wait), int'(m_rem > 0));
    chk("R3 fl_prog", int'(fl_prog), int'(m_prog));
    chk("R9 fl_erase", int'(fl_erase), int'(m_erase));
    chk("R3/R9 fl_addr", int'(fl_addr), m_faddr);
    chk("R3 fl_data", int'(fl_data), m_fdata);
  end

  function automatic int mreg(input int a);
    case (a)
      0: return m_col; 1: return m_page; 2: return m_row; 3: return m_data;
      4: return m_div; 6: return m_err | int'(m_rem > 0);
      default: return 0;
    endcase
  endfunction

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); io_addr = 3'(a); #1;
    chk(tag, int'(io_rdata), exp);
    chk({tag, " model"}, int'(io_rdata), mreg(a));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); io_wr = 1'b1; io_addr = 3'(a); io_wdata = 8'(d);
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic prog(input int d, output int len);
    wr(3, d);
    len = 0;
    while (cpu_wait) begin len++; @(negedge clk); end
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) rd(a, 0, "R1 reset value");

    prog(8'h11, len);
    chk("R8 div-zero wait length", len, 1);
    rd(6, 8'h08, "R7 div-zero error bit");
    wr(6, 8'h08);
    rd(6, 8'h00, "R10 write-one-clear");

    wr(4, 3); wr(0, 5); wr(1, 1); wr(2, 0);
    rd(0, 5, "R1 column readback");
    wr(3, 8'hA5);
    rd(6, 8'h01, "R10 busy mirrors wait");
    wr(4, 9);
    len = 0;
    while (cpu_wait) begin len++; @(negedge clk); end
    chk("R3 R4 pulse length div=3", len + 3, P * 3);
    rd(4, 3, "R11 write during busy ignored");
    rd(3, 8'hA5, "R1 data readback");

    prog(8'h5A, len);
    chk("R3 second program accepted", len, P * 3);
    prog(8'h3C, len);
    chk("R8 repeat refusal wait length", len, 1);
    rd(6, 8'h02, "R5 repeat error bit");

    wr(5, 1);
    prog(8'h77, len);
    chk("R9 program after erase", len, P * 3);
    rd(6, 8'h02, "R10 error bit sticky");
    wr(6, 8'h0E);

    wr(4, 1); wr(1, 0); wr(2, 1);
    for (int pass = 0; pass < 2; pass++)
      for (int c = 0; c < 128; c++) begin
        if (pass == 1 && c > 85) break;
        wr(0, c);
        prog(c ^ pass, len);
      end
    chk("R6 budget refusal wait length", len, 1);
    rd(6, 8'h04, "R6 budget error bit");
    wr(6, 8'h04);

    wr(0, 0);
    prog(8'h01, len);
    rd(6, 8'h02, "R5 repeat precedes budget");
    wr(6, 8'h02);
    wr(4, 0);
    prog(8'h01, len);
    rd(6, 8'h08, "R7 divider precedes others");
    wr(6, 8'h08);

    wr(4, 2); wr(0, 100);
    prog(8'h42, len);
    rd(6, 8'h04, "R6 budget still exhausted");
    wr(6, 8'h04);
    wr(5, 1);
    prog(8'h42, len);
    chk("R9 R4 erase restores budget, div=2", len, P * 2);
    rd(6, 8'h00, "R9 no error after erase");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule